// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter

This block decides who drives a shared bus: a CPU bus master or one of two DMA channels. Each channel's request line is sampled once per bus-clock period, on the falling edge. A detected request from an enabled channel raises that channel's one-bit pending flag on the following rising edge. The flag does not count requests: any number of requests that arrive while it is set add up to a single transfer.

The CPU owns the bus by default. The bus changes hands only on two single-cycle strobes. When the CPU reports a finished access and at least one flag is pending, the lowest-numbered pending channel takes the bus on the next cycle, and its flag clears in that same cycle. When the channel reports a finished transfer, the bus goes back to the CPU. A pending channel therefore always waits for a CPU access to complete between two DMA transfers. A request seen while its channel is transferring re-arms the flag, and that channel is served again after the next CPU access.

The address and count registers and the data movement itself belong to the surrounding DMA controller, which drives the transfer-done strobe.

Top module: `dma_req_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cpu_gnt` is 1, `dma_gnt` is 0 and `pend` is 0.
- R2: `dma_req[k]` is sampled on the falling edge of `clk`. A sampled 1 on an enabled channel sets `pend[k]` on the next rising edge. When both channels are detected in the same period, both bits of `pend` become 1 on the same edge.
- R3: A channel whose `ch_en[k]` is 0 never sets `pend[k]`, whatever its request line does.
- R4: If `cpu_done` is 1 while the CPU holds the bus and any `pend` bit is set, the lowest-numbered pending channel is granted on the next cycle. Channel 0 beats channel 1. If no bit is set, the CPU keeps the bus.
- R5: A channel's `pend` bit clears on the same edge that raises its `dma_gnt` bit, unless a new request is detected in that same period.
- R6: A granted `dma_gnt` bit stays unchanged until `xfer_done` is 1. The cycle after `xfer_done`, `cpu_gnt` is 1. A `cpu_done` pulse during a DMA transfer has no effect.
- R7: While the CPU holds the bus, it keeps it in every cycle without `cpu_done`. Between any two DMA transfers there is always at least one completed CPU access.
- R8: Several requests from one channel that are detected while its flag is already set produce exactly one transfer.
- R9: A request detected during its own channel's transfer sets `pend[k]` again. That channel is granted again after the next CPU access.
- R10: In every cycle, exactly one bit of {`dma_gnt`, `cpu_gnt`} is 1. Bit k of `dma_gnt` and of `pend` belongs to channel k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; requests are sampled on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NUM_CH | Per-channel enable |
| dma_req | input | NUM_CH | Per-channel request lines |
| cpu_done | input | 1 | Single-cycle strobe: the CPU finished one bus access |
| xfer_done | input | 1 | Single-cycle strobe: the granted channel finished one transfer |
| dma_gnt | output | NUM_CH | One-hot grant to a DMA channel |
| cpu_gnt | output | 1 | The CPU owns the bus |
| pend | output | NUM_CH | Pending flags, one per channel |

## Verification
A corrupted pending flag shows up on `pend` one rising edge after the faulty sampling period. The bench then sees a grant too many or too few on the next `cpu_done`. A wrong owner state shows up immediately as a grant vector that is not one-hot, or as a grant that moves without a strobe. A wrong priority or a missing CPU slot changes the order of grants, so the scoreboard, which expects a fixed channel sequence, flags it at the first grant edge that breaks the order.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int MAX_CH = 8;

    typedef enum logic {
        OWN_CPU = 1'b0,
        OWN_DMA = 1'b1
    } owner_e;

    // Isolate the lowest set bit: lowest index has highest priority.
    function automatic logic [MAX_CH-1:0] lowest_set(input logic [MAX_CH-1:0] v);
        return v & (~v + MAX_CH'(1));
    endfunction

endpackage

// File: rtl/dma_req_sampler.sv
module dma_req_sampler #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req_in,
    output logic [NUM_CH-1:0] smp
);

    // Sampling period runs falling edge to falling edge.
    always_ff @(negedge clk) begin
        if (rst) smp <= '0;
        else     smp <= req_in;
    end

endmodule

// File: rtl/dma_pend_flags.sv
module dma_pend_flags #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] smp,
    input  logic [NUM_CH-1:0] en,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] pend
);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_flag
        logic det;
        assign det = smp[k] & en[k];

        // Single bit, no counting; a fresh detection beats the grant clear.
        always_ff @(posedge clk) begin
            if (rst) pend[k] <= 1'b0;
            else     pend[k] <= (pend[k] & ~clr[k]) | det;
        end

        // R2
        set_on_detect_chk: assert property (@(posedge clk) disable iff (rst)
            (smp[k] && en[k]) |=> pend[k]);

        // R3
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (!pend[k] && !en[k]) |=> !pend[k]);
    end

endmodule

// File: rtl/dma_owner_fsm.sv
module dma_owner_fsm
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pend,
    input  logic              cpu_done,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] gnt,
    output logic              cpu_gnt,
    output logic [NUM_CH-1:0] clr
);

    owner_e             owner_q;
    logic [NUM_CH-1:0]  gnt_q;
    logic [MAX_CH-1:0]  pick_full;
    logic [NUM_CH-1:0]  pick;
    logic               hand_over;

    assign pick_full = lowest_set(MAX_CH'(pend));
    assign pick      = NUM_CH'(pick_full);
    assign hand_over = (owner_q == OWN_CPU) && cpu_done && (|pend);
    assign clr       = hand_over ? pick : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_CPU;
            gnt_q   <= '0;
        end else if (hand_over) begin
            owner_q <= OWN_DMA;
            gnt_q   <= pick;
        end else if ((owner_q == OWN_DMA) && xfer_done) begin
            owner_q <= OWN_CPU;
            gnt_q   <= '0;
        end
    end

    assign gnt     = gnt_q;
    assign cpu_gnt = (owner_q == OWN_CPU);

    // R6
    dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((|gnt) && !xfer_done) |=> $stable(gnt));

    // R6
    dma_return_chk: assert property (@(posedge clk) disable iff (rst)
        ((|gnt) && xfer_done) |=> cpu_gnt);

    // R7
    cpu_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt && !cpu_done) |=> cpu_gnt);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] dma_req,
    input  logic              cpu_done,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] dma_gnt,
    output logic              cpu_gnt,
    output logic [NUM_CH-1:0] pend
);

    logic [NUM_CH-1:0] smp;
    logic [NUM_CH-1:0] clr;

    dma_req_sampler #(.NUM_CH(NUM_CH)) sampler_i (
        .clk    (clk),
        .rst    (rst),
        .req_in (dma_req),
        .smp    (smp)
    );

    dma_pend_flags #(.NUM_CH(NUM_CH)) flags_i (
        .clk  (clk),
        .rst  (rst),
        .smp  (smp),
        .en   (ch_en),
        .clr  (clr),
        .pend (pend)
    );

    dma_owner_fsm #(.NUM_CH(NUM_CH)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .cpu_done  (cpu_done),
        .xfer_done (xfer_done),
        .gnt       (dma_gnt),
        .cpu_gnt   (cpu_gnt),
        .clr       (clr)
    );

    // R10
    one_owner_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({dma_gnt, cpu_gnt}) == 1);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        localparam logic [NUM_CH-1:0] LOWER = NUM_CH'((1 << k) - 1);

        // R4
        prio_pick_chk: assert property (@(posedge clk) disable iff (rst)
            (cpu_gnt && cpu_done && pend[k] && ((pend & LOWER) == '0)) |=> dma_gnt[k]);

        // R5
        clr_on_gnt_chk: assert property (@(posedge clk) disable iff (rst)
            (cpu_gnt && cpu_done && pend[k] && ((pend & LOWER) == '0)
             && !(smp[k] && ch_en[k])) |=> !pend[k]);
    end

endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] ch_en = '1;
    logic [NCH-1:0] dma_req = '0;
    logic           cpu_done = 1'b0;
    logic           xfer_done = 1'b0;
    logic [NCH-1:0] dma_gnt;
    logic           cpu_gnt;
    logic [NCH-1:0] pend;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    logic [NCH-1:0] prev_gnt = '0;
    bit done_flag = 1'b0;

    dma_req_arbiter #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .ch_en(ch_en), .dma_req(dma_req),
        .cpu_done(cpu_done), .xfer_done(xfer_done),
        .dma_gnt(dma_gnt), .cpu_gnt(cpu_gnt), .pend(pend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cpu_access();
        cpu_done = 1'b1; tick(); cpu_done = 1'b0;
    endtask

    task automatic xfer_end();
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    endtask

    // Monitor: pops the expected grant order and checks ownership every cycle.
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            chk($countones({dma_gnt, cpu_gnt}) == 1, "R10", int'({dma_gnt, cpu_gnt}), 0);
            if (dma_gnt != '0 && dma_gnt != prev_gnt) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected grant", int'(dma_gnt), 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(dma_gnt == NCH'(1 << e), "R4 grant order", int'(dma_gnt), 1 << e);
                end
            end
            prev_gnt = dma_gnt;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state while held
        chk(cpu_gnt == 1'b1, "R1", int'(cpu_gnt), 1);
        chk(dma_gnt == '0, "R1", int'(dma_gnt), 0);
        rst = 1'b0;
        tick();
        chk(pend == '0 && cpu_gnt, "R1", int'(pend), 0);

        // R2 both channels detected in one period; R4 channel 0 first
        exp_q.push_back(0); exp_q.push_back(1);
        dma_req = 2'b11; tick(); dma_req = 2'b00;
        chk(pend == 2'b11, "R2", int'(pend), 3);
        cpu_access();
        chk(dma_gnt == 2'b01, "R4", int'(dma_gnt), 1);
        chk(pend == 2'b10, "R5", int'(pend), 2);
        tick();
        cpu_access();                         // ignored during DMA
        tick();
        chk(dma_gnt == 2'b01 && !cpu_gnt, "R6", int'(dma_gnt), 1);
        xfer_end();
        chk(cpu_gnt && dma_gnt == '0, "R6", int'(cpu_gnt), 1);
        chk(pend == 2'b10, "R7", int'(pend), 2);
        repeat (3) tick();
        chk(cpu_gnt && dma_gnt == '0, "R7", int'(dma_gnt), 0);
        cpu_access();
        chk(dma_gnt == 2'b10, "R4", int'(dma_gnt), 2);
        chk(pend == 2'b00, "R5", int'(pend), 0);
        xfer_end();

        // R8 repeated requests collapse into one transfer
        exp_q.push_back(1);
        dma_req = 2'b10; repeat (4) tick(); dma_req = 2'b00;
        chk(pend == 2'b10, "R8", int'(pend), 2);
        cpu_access();
        chk(dma_gnt == 2'b10 && pend == 2'b00, "R8", int'(pend), 0);
        xfer_end();
        cpu_access();
        chk(cpu_gnt && dma_gnt == '0, "R8", int'(dma_gnt), 0);

        // R9 re-arm during own transfer
        exp_q.push_back(0); exp_q.push_back(0);
        dma_req = 2'b01; tick(); dma_req = 2'b00;
        cpu_access();
        chk(dma_gnt == 2'b01 && pend == 2'b00, "R5", int'(pend), 0);
        dma_req = 2'b01; tick(); dma_req = 2'b00;
        chk(pend == 2'b01 && dma_gnt == 2'b01, "R9", int'(pend), 1);
        xfer_end();
        chk(cpu_gnt && pend == 2'b01, "R9", int'(pend), 1);
        cpu_access();
        chk(dma_gnt == 2'b01, "R9", int'(dma_gnt), 1);
        xfer_end();

        // R3 disabled channel never flags
        exp_q.push_back(1);
        ch_en = 2'b10;
        dma_req = 2'b11; repeat (2) tick(); dma_req = 2'b00;
        chk(pend == 2'b10, "R3", int'(pend), 2);
        cpu_access();
        chk(dma_gnt == 2'b10 && pend == 2'b00, "R3", int'(pend), 0);
        xfer_end();
        ch_en = 2'b11;

        // R4 channel 0 wins even when channel 1 arrived earlier
        exp_q.push_back(0); exp_q.push_back(1);
        dma_req = 2'b10; tick(); dma_req = 2'b00;
        chk(pend == 2'b10, "R2", int'(pend), 2);
        dma_req = 2'b01; tick(); dma_req = 2'b00;
        chk(pend == 2'b11, "R2", int'(pend), 3);
        cpu_access();
        chk(dma_gnt == 2'b01, "R4", int'(dma_gnt), 1);
        xfer_end();
        cpu_access();
        chk(dma_gnt == 2'b10, "R4", int'(dma_gnt), 2);
        xfer_end();
        repeat (2) tick();

        chk(exp_q.size() == 0, "R4 missing grants", exp_q.size(), 0);
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule